// File: doc/BRIEF.md
# Instruction-Driven Port Controller

This block holds the output latches and direction state for five 4-bit port slots of a small controller. It takes one decoded port command per clock. Each command carries an operation code, a port number and a 4-bit argument that serves as data or mask. One cycle later the block returns read data and a skip flag. It also drives the pin output values, output enables and open-drain pull-downs.

Two of the slots are bidirectional. The first has no direction register: any read or test sets all four pins to input, and any write or bit change sets all four to output. The second takes a separate direction value for each pin from a latch loaded by a dedicated command. The remaining slots are a plain input slot, a push-pull output slot and an open-drain output slot.

A level-sensitive backup input puts every pin into a quiet state, disables inputs and freezes the stored latches. Reset forces the push-pull pins low and leaves every other pin floating.

Top module: `gpio_port_ctl`

## Requirements
- R1: While `rst_n` is low, `pp_oe` is 4'hF with `pp_out` 0, `auto_oe`, `pin_oe` and `od_pull_low` are 0, and the response is 0. After reset all latches are 0, except the open-drain latch, which is 4'hF (released).
- R2: Opcodes are 0 none, 1 read, 2 write, 3 set-bits, 4 clear-bits, 5 test-all-ones, 6 test-all-zeros and 7 load-direction. Port numbers are 0 input, 1 auto-direction, 2 per-pin direction, 3 push-pull and 4 open-drain. A read of port 0 returns `in_pins` on `rsp_data` in the cycle after the command, with `rsp_skip` 0.
- R3: On port 1, a read or either test sets all pins to input (`auto_oe` 0). A write, set-bits or clear-bits sets all pins to output (`auto_oe` 4'hF). A read or test of port 1 returns `auto_pins_in`.
- R4: Output latch contents are kept while a port is in input mode, and `auto_out` always shows the port 1 latch.
- R5: Opcode 7 loads `cmd_arg` into the port 2 direction latch for any port number (bit 1 = output), and `pin_oe` follows it. A read of port 2 returns the pin input for input bits and the latch for output bits. Writes leave the direction unchanged.
- R6: Set-bits ORs the mask into the selected latch. Clear-bits clears the masked bits. Write loads the argument. Bits outside the mask are kept.
- R7: Test-all-ones sets `rsp_skip` when every masked bit of the read value is 1. Test-all-zeros sets it when every masked bit is 0. An empty mask always skips. Tests return `rsp_data` 0.
- R8: Out of reset and backup, `pp_oe` is 4'hF and `pp_out` equals the port 3 latch. Reads of ports 3 and 4 return their latches.
- R9: Out of reset and backup, `od_pull_low` is the inverse of the port 4 latch: a 0 bit pulls low and a 1 bit releases the pin.
- R10: While `backup` is high, all enables and pull-downs are 0, `pp_out` is 0, every command is ignored and the response is 0. After backup, the latches and direction latch are as before, and port 1 is in input mode.
- R11: Writes, bit changes and tests addressed to port 0 or to port numbers 5 to 7 change no output, and reads of port numbers 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also gates pins directly |
| backup | input | 1 | Backup mode level |
| cmd_op | input | 3 | Operation code |
| cmd_port | input | 3 | Port number |
| cmd_arg | input | 4 | Data or bit mask |
| in_pins | input | 4 | Port 0 pin inputs |
| auto_pins_in | input | 4 | Port 1 pin inputs |
| pin_pins_in | input | 4 | Port 2 pin inputs |
| rsp_data | output | 4 | Read data, one cycle after the command |
| rsp_skip | output | 1 | Test result, one cycle after the command |
| auto_out | output | 4 | Port 1 output values |
| auto_oe | output | 4 | Port 1 output enables |
| pin_out | output | 4 | Port 2 output values |
| pin_oe | output | 4 | Port 2 output enables |
| pp_out | output | 4 | Port 3 output values |
| pp_oe | output | 4 | Port 3 output enables |
| od_pull_low | output | 4 | Port 4 pull-down enables |

## Verification
The properties assume that `backup` and `rst_n` are levels held for whole cycles, and that the command fields are stable around the sampling edge. The bench drives every input only on the falling edge. It changes `backup` only between commands, so any property that compares a latch across one cycle sees an unbroken stretch of normal operation. It sweeps every pin value against every mask for both tests, and every start value against every mask for set and clear. It also sweeps all sixteen direction patterns.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
    localparam int PW  = 4;
    localparam int OPW = 3;
    localparam int PNW = 3;

    typedef enum logic [OPW-1:0] {
        CMD_NONE  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_SET   = 3'd3,
        CMD_CLR   = 3'd4,
        CMD_TALL1 = 3'd5,
        CMD_TALL0 = 3'd6,
        CMD_DIR   = 3'd7
    } cmd_e;

    localparam logic [PNW-1:0] PORT_IN   = 3'd0;
    localparam logic [PNW-1:0] PORT_AUTO = 3'd1;
    localparam logic [PNW-1:0] PORT_PIN  = 3'd2;
    localparam logic [PNW-1:0] PORT_PP   = 3'd3;
    localparam logic [PNW-1:0] PORT_OD   = 3'd4;

    typedef struct packed {
        logic [PW-1:0] auto_lat;
        logic          auto_drv;
        logic [PW-1:0] pin_lat;
        logic [PW-1:0] pin_dir;
        logic [PW-1:0] pp_lat;
        logic [PW-1:0] od_lat;
        logic [PW-1:0] rsp_data;
        logic          rsp_skip;
    } ctl_state_t;
endpackage

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_ctl_pkg::*;
(
    input  logic [PNW-1:0] port_sel,
    input  logic [PW-1:0]  in_pins,
    input  logic [PW-1:0]  auto_pins,
    input  logic [PW-1:0]  pin_pins,
    input  logic [PW-1:0]  pin_lat,
    input  logic [PW-1:0]  pin_dir,
    input  logic [PW-1:0]  pp_lat,
    input  logic [PW-1:0]  od_lat,
    output logic [PW-1:0]  value
);
    always_comb begin
        case (port_sel)
            PORT_IN:   value = in_pins;
            PORT_AUTO: value = auto_pins;
            PORT_PIN:  value = (pin_pins & ~pin_dir) | (pin_lat & pin_dir);
            PORT_PP:   value = pp_lat;
            PORT_OD:   value = od_lat;
            default:   value = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mask_test.sv
module gpio_mask_test
    import gpio_ctl_pkg::*;
(
    input  logic [PW-1:0] value,
    input  logic [PW-1:0] mask,
    output logic          all_ones,
    output logic          all_zeros
);
    assign all_ones  = &(value | ~mask);
    assign all_zeros = ~|(value & mask);
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_ctl_pkg::*;
(
    input  logic          rst_n,
    input  logic          backup,
    input  ctl_state_t    st,
    output logic [PW-1:0] auto_out,
    output logic [PW-1:0] auto_oe,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [PW-1:0] pp_out,
    output logic [PW-1:0] pp_oe,
    output logic [PW-1:0] od_pull_low
);
    logic live;
    assign live = rst_n & ~backup;

    assign auto_out = st.auto_lat;
    assign pin_out  = st.pin_lat;

    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign auto_oe[i]     = live & st.auto_drv;
        assign pin_oe[i]      = live & st.pin_dir[i];
        assign pp_out[i]      = live & st.pp_lat[i];
        assign pp_oe[i]       = ~backup;
        assign od_pull_low[i] = live & ~st.od_lat[i];
    end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           backup,
    input  logic [OPW-1:0] cmd_op,
    input  logic [PNW-1:0] cmd_port,
    input  logic [PW-1:0]  cmd_arg,
    input  logic [PW-1:0]  in_pins,
    input  logic [PW-1:0]  auto_pins_in,
    input  logic [PW-1:0]  pin_pins_in,
    output logic [PW-1:0]  rsp_data,
    output logic           rsp_skip,
    output logic [PW-1:0]  auto_out,
    output logic [PW-1:0]  auto_oe,
    output logic [PW-1:0]  pin_out,
    output logic [PW-1:0]  pin_oe,
    output logic [PW-1:0]  pp_out,
    output logic [PW-1:0]  pp_oe,
    output logic [PW-1:0]  od_pull_low
);
    localparam ctl_state_t RST_ST = '{
        auto_lat: '0, auto_drv: 1'b0, pin_lat: '0, pin_dir: '0,
        pp_lat: '0, od_lat: '1, rsp_data: '0, rsp_skip: 1'b0
    };

    ctl_state_t    st_q, st_d;
    cmd_e          op;
    logic [PW-1:0] rd_val;
    logic          t_ones, t_zeros;
    logic          is_wr, is_rd;

    assign op    = cmd_e'(cmd_op);
    assign is_wr = (op == CMD_WRITE) || (op == CMD_SET) || (op == CMD_CLR);
    assign is_rd = (op == CMD_READ) || (op == CMD_TALL1) || (op == CMD_TALL0);

    gpio_read_mux u_rmux (
        .port_sel  (cmd_port),
        .in_pins   (in_pins),
        .auto_pins (auto_pins_in),
        .pin_pins  (pin_pins_in),
        .pin_lat   (st_q.pin_lat),
        .pin_dir   (st_q.pin_dir),
        .pp_lat    (st_q.pp_lat),
        .od_lat    (st_q.od_lat),
        .value     (rd_val)
    );

    gpio_mask_test u_test (
        .value     (rd_val),
        .mask      (cmd_arg),
        .all_ones  (t_ones),
        .all_zeros (t_zeros)
    );

    function automatic logic [PW-1:0] upd(input cmd_e o, input logic [PW-1:0] cur,
                                          input logic [PW-1:0] arg);
        case (o)
            CMD_WRITE: return arg;
            CMD_SET:   return cur | arg;
            CMD_CLR:   return cur & ~arg;
            default:   return cur;
        endcase
    endfunction

    always_comb begin
        st_d          = st_q;
        st_d.rsp_data = '0;
        st_d.rsp_skip = 1'b0;
        if (backup) begin
            st_d.auto_drv = 1'b0;
        end else begin
            case (op)
                CMD_READ:  st_d.rsp_data = rd_val;
                CMD_TALL1: st_d.rsp_skip = t_ones;
                CMD_TALL0: st_d.rsp_skip = t_zeros;
                CMD_DIR:   st_d.pin_dir  = cmd_arg;
                default: ;
            endcase
            if (is_wr) begin
                case (cmd_port)
                    PORT_AUTO: begin
                        st_d.auto_lat = upd(op, st_q.auto_lat, cmd_arg);
                        st_d.auto_drv = 1'b1;
                    end
                    PORT_PIN: st_d.pin_lat = upd(op, st_q.pin_lat, cmd_arg);
                    PORT_PP:  st_d.pp_lat  = upd(op, st_q.pp_lat, cmd_arg);
                    PORT_OD:  st_d.od_lat  = upd(op, st_q.od_lat, cmd_arg);
                    default: ;
                endcase
            end
            if (is_rd && cmd_port == PORT_AUTO) begin
                st_d.auto_drv = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign rsp_data = st_q.rsp_data;
    assign rsp_skip = st_q.rsp_skip;

    gpio_pin_drive u_drive (
        .rst_n       (rst_n),
        .backup      (backup),
        .st          (st_q),
        .auto_out    (auto_out),
        .auto_oe     (auto_oe),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .pp_out      (pp_out),
        .pp_oe       (pp_oe),
        .od_pull_low (od_pull_low)
    );
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk
    import gpio_ctl_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           backup,
    input logic [OPW-1:0] cmd_op,
    input logic [PNW-1:0] cmd_port,
    input logic [PW-1:0]  cmd_arg,
    input logic [PW-1:0]  rsp_data,
    input logic           rsp_skip,
    input logic [PW-1:0]  auto_oe,
    input logic [PW-1:0]  pin_oe,
    input logic [PW-1:0]  pp_out,
    input logic [PW-1:0]  pp_oe,
    input logic [PW-1:0]  od_pull_low
);
    logic wr_op, rd_op, tst_op;
    assign wr_op  = (cmd_op == CMD_WRITE) || (cmd_op == CMD_SET) || (cmd_op == CMD_CLR);
    assign tst_op = (cmd_op == CMD_TALL1) || (cmd_op == CMD_TALL0);
    assign rd_op  = (cmd_op == CMD_READ) || tst_op;

    // R10
    backup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup |-> (auto_oe == '0 && pin_oe == '0 && pp_oe == '0 &&
                    od_pull_low == '0 && pp_out == '0));

    // R10
    backup_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup |=> (rsp_data == '0 && !rsp_skip));

    // R3
    auto_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && cmd_port == PORT_AUTO && wr_op) |=> (backup || auto_oe == '1));

    // R3
    auto_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && cmd_port == PORT_AUTO && rd_op) |=> (auto_oe == '0));

    // R5
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && cmd_op == CMD_DIR) |=> (backup || pin_oe == $past(cmd_arg)));

    // R6
    pp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!backup && cmd_op == CMD_SET && cmd_port == PORT_PP)
        |=> (backup || pp_out == ($past(pp_out) | $past(cmd_arg))));

    // R7
    skip_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tst_op && !backup) |=> !rsp_skip);

    // R8
    pp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !backup |-> (pp_oe == '1));
endmodule

bind gpio_port_ctl gpio_port_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .backup      (backup),
    .cmd_op      (cmd_op),
    .cmd_port    (cmd_port),
    .cmd_arg     (cmd_arg),
    .rsp_data    (rsp_data),
    .rsp_skip    (rsp_skip),
    .auto_oe     (auto_oe),
    .pin_oe      (pin_oe),
    .pp_out      (pp_out),
    .pp_oe       (pp_oe),
    .od_pull_low (od_pull_low)
);

// File: tb/gpio_port_ctl_test.sv
module gpio_port_ctl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       backup = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_port = 3'd0;
    logic [3:0] cmd_arg = 4'd0;
    logic [3:0] in_pins = 4'd0, auto_pins_in = 4'd0, pin_pins_in = 4'd0;
    logic [3:0] rsp_data, auto_out, auto_oe, pin_out, pin_oe, pp_out, pp_oe, od_pull_low;
    logic       rsp_skip;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_port_ctl uut (
        .clk(clk), .rst_n(rst_n), .backup(backup), .cmd_op(cmd_op),
        .cmd_port(cmd_port), .cmd_arg(cmd_arg), .in_pins(in_pins),
        .auto_pins_in(auto_pins_in), .pin_pins_in(pin_pins_in),
        .rsp_data(rsp_data), .rsp_skip(rsp_skip), .auto_out(auto_out),
        .auto_oe(auto_oe), .pin_out(pin_out), .pin_oe(pin_oe),
        .pp_out(pp_out), .pp_oe(pp_oe), .od_pull_low(od_pull_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive on a falling edge, return on the next falling edge with results settled
    task automatic issue(input logic [2:0] op, input logic [2:0] port, input logic [3:0] arg);
        cmd_op = op; cmd_port = port; cmd_arg = arg;
        @(negedge clk);
        cmd_op = 3'd0; cmd_port = 3'd0; cmd_arg = 4'd0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 pp_oe", pp_oe, 4'hF);
        chk("R1 pp_out", pp_out, 0);
        chk("R1 auto_oe", auto_oe, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 od_pull_low", od_pull_low, 0);
        chk("R1 rsp", {rsp_skip, rsp_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 od released after reset", od_pull_low, 0);
        chk("R1 pp latch clear", pp_out, 0);

        // R2 reads of input port
        for (int v = 0; v < 16; v++) begin
            in_pins = 4'(v);
            issue(3'd1, 3'd0, 4'd0);
            chk("R2 read port0", {rsp_skip, rsp_data}, v);
        end

        // R7 test sweep over value and mask
        for (int v = 0; v < 16; v++) begin
            for (int m = 0; m < 16; m++) begin
                in_pins = 4'(v);
                issue(3'd5, 3'd0, 4'(m));
                chk("R7 all-ones skip", rsp_skip, ((v & m) == m) ? 1 : 0);
                chk("R7 test data", rsp_data, 0);
                issue(3'd6, 3'd0, 4'(m));
                chk("R7 all-zeros skip", rsp_skip, ((v & m) == 0) ? 1 : 0);
            end
        end

        // R6 R8 set/clear sweep on push-pull port
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                issue(3'd2, 3'd3, 4'(s));
                chk("R8 pp_out after write", pp_out, s);
                issue(3'd3, 3'd3, 4'(m));
                chk("R6 set bits", pp_out, (s | m) & 15);
                issue(3'd2, 3'd3, 4'(s));
                issue(3'd4, 3'd3, 4'(m));
                chk("R6 clear bits", pp_out, s & ~m & 15);
            end
        end
        issue(3'd2, 3'd3, 4'h6);
        issue(3'd1, 3'd3, 4'd0);
        chk("R8 read pp latch", rsp_data, 4'h6);
        chk("R8 pp_oe", pp_oe, 4'hF);

        // R3 R4 auto-direction port
        issue(3'd2, 3'd1, 4'h5);
        chk("R3 write -> output", auto_oe, 4'hF);
        chk("R4 auto_out", auto_out, 4'h5);
        auto_pins_in = 4'hA;
        issue(3'd1, 3'd1, 4'd0);
        chk("R3 read -> input", auto_oe, 0);
        chk("R3 read returns pins", rsp_data, 4'hA);
        chk("R4 latch kept in input", auto_out, 4'h5);
        issue(3'd3, 3'd1, 4'h2);
        chk("R3 set -> output", auto_oe, 4'hF);
        chk("R4 set keeps old bits", auto_out, 4'h7);
        issue(3'd6, 3'd1, 4'h5);
        chk("R3 test-zeros -> input", auto_oe, 0);
        chk("R3 test uses pins", rsp_skip, 1);
        issue(3'd4, 3'd1, 4'h1);
        chk("R3 clear -> output", auto_oe, 4'hF);
        chk("R6 clear auto", auto_out, 4'h6);
        issue(3'd5, 3'd1, 4'h8);
        chk("R3 test-ones -> input", auto_oe, 0);
        chk("R3 test-ones pins", rsp_skip, 1);

        // R5 per-pin direction
        issue(3'd2, 3'd2, 4'hA);
        pin_pins_in = 4'h5;
        for (int m = 0; m < 16; m++) begin
            issue(3'd7, 3'(m % 5), 4'(m));
            chk("R5 pin_oe", pin_oe, m);
            issue(3'd1, 3'd2, 4'd0);
            chk("R5 mixed read", rsp_data, ((5 & ~m) | (10 & m)) & 15);
        end
        issue(3'd7, 3'd0, 4'h3);
        issue(3'd2, 3'd2, 4'hC);
        chk("R5 write keeps dir", pin_oe, 4'h3);
        chk("R5 pin_out latch", pin_out, 4'hC);

        // R9 open-drain
        for (int s = 0; s < 16; s++) begin
            issue(3'd2, 3'd4, 4'(s));
            chk("R9 pull low inverse", od_pull_low, ~s & 15);
        end

        // R11 ignored ports
        issue(3'd2, 3'd3, 4'h9);
        issue(3'd2, 3'd4, 4'h2);
        for (int p = 5; p < 8; p++) begin
            issue(3'd2, 3'(p), 4'hF);
            issue(3'd3, 3'(p), 4'hF);
            issue(3'd4, 3'(p), 4'hF);
            in_pins = 4'hF;
            issue(3'd1, 3'(p), 4'd0);
            chk("R11 unused read zero", rsp_data, 0);
        end
        issue(3'd2, 3'd0, 4'hF);
        issue(3'd4, 3'd0, 4'hF);
        chk("R11 pp unchanged", pp_out, 4'h9);
        chk("R11 od unchanged", od_pull_low, 4'hD);
        chk("R11 pin unchanged", pin_out, 4'hC);
        chk("R11 auto unchanged", auto_out, 4'h6);

        // R10 backup
        issue(3'd2, 3'd1, 4'h6);
        issue(3'd7, 3'd0, 4'hF);
        backup = 1'b1;
        #1;
        chk("R10 auto_oe", auto_oe, 0);
        chk("R10 pin_oe", pin_oe, 0);
        chk("R10 pp_oe", pp_oe, 0);
        chk("R10 pp_out", pp_out, 0);
        chk("R10 od released", od_pull_low, 0);
        @(negedge clk);
        issue(3'd2, 3'd3, 4'hF);
        issue(3'd7, 3'd0, 4'h0);
        issue(3'd2, 3'd4, 4'hF);
        in_pins = 4'hF;
        issue(3'd1, 3'd0, 4'd0);
        chk("R10 read disabled", rsp_data, 0);
        issue(3'd6, 3'd0, 4'hF);
        chk("R10 no skip", rsp_skip, 0);
        backup = 1'b0;
        #1;
        chk("R10 pp retained", pp_out, 4'h9);
        chk("R10 auto now input", auto_oe, 0);
        chk("R10 auto latch", auto_out, 4'h6);
        chk("R10 dir retained", pin_oe, 4'hF);
        chk("R10 od retained", od_pull_low, 4'hD);

        // R1 reset asserted mid-run
        @(negedge clk);
        issue(3'd2, 3'd3, 4'hF);
        rst_n = 1'b0;
        #1;
        chk("R1 pp low in reset", pp_out, 0);
        chk("R1 pin floats in reset", pin_oe, 0);
        chk("R1 od floats in reset", od_pull_low, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 latch cleared", pp_out, 0);
        chk("R1 dir cleared", pin_oe, 0);

        finish_run();
    end
endmodule